// File: doc/BRIEF.md
# Audio Transmit Slot Drift Compensator

This block sits between the sample FIFO of a serial audio transmitter and its serializer. It keeps several transmit ports aligned in time. Each port receives the same periodic checkpoint pulse. At each checkpoint the block compares the number of slots it has pulled from the FIFO since the last checkpoint with a programmed target count. It then takes one of three actions: it does nothing, it inserts filler samples on its own, or it raises an interrupt so that software can deal with severe drift.

The serializer marks every slot boundary with `slot_tick`. In that cycle the block either passes `src_data` to `line_data` and pops the FIFO (`src_pop`), or it sends a filler sample without popping. The filler is either the last sample sent or a programmed 32-bit constant. Bit-clock ticks are counted separately so that software can compare line activity with FIFO activity. The checkpoint input `sync_in` is asynchronous. It passes through a two-flop synchronizer and a rising-edge detector before use.

The core is a three-state machine:
- **TRACK** is normal passthrough.
- **JUDGE** is the single cycle after a checkpoint, in which the captured shortfall is classified.
- **FILL** inserts filler samples.

The transitions are:
- any state → JUDGE on a checkpoint edge;
- JUDGE → FILL when the shortfall lies inside the threshold band and insertion is enabled;
- JUDGE → TRACK otherwise;
- FILL → TRACK when the shortfall reaches zero, when insertion is disabled, or when the shortfall is cleared by software.

Top module: `txdc_top`

## Requirements
- R1: A level held high on `sync_in` gives exactly one checkpoint. It takes effect on the third rising clock edge after it is first sampled, through two synchronizer flops and a rising-edge detector.
- R2: The line counter (register 5) counts `bclk_tick` cycles. The FIFO counter (register 6) counts slots popped from the FIFO (`src_pop`). Inserted filler slots are not counted.
- R3: A checkpoint clears both counters. A slot popped in the checkpoint cycle itself counts as 1 in the new interval and is left out of the captured shortfall. A write to CTRL with bit 3 set clears only the line counter, and with bit 4 set clears only the FIFO counter.
- R4: At each checkpoint the shortfall (register 7) is captured as target (register 3) minus FIFO count, saturating at 0. A write to CTRL with bit 5 set clears it.
- R5: A shortfall below the active low threshold (register 1) causes no action: following slots pass through and pop.
- R6: A shortfall from the low threshold up to and including the active high threshold (register 2), with insertion enabled (CTRL bit 0), makes the next shortfall-many slots filler samples without a pop. Each filler sample lowers the shortfall by one.
- R7: A shortfall above the high threshold sets the sticky `irq` output (also CTRL read bit 8) and inserts nothing. A write to CTRL with bit 6 set clears `irq`.
- R8: CTRL bit 1 selects the filler: 0 repeats the last sample sent on the line, and 1 sends the 32-bit constant in register 4.
- R9: With CTRL bit 0 at 0, the counters and the shortfall capture still work, but no filler is inserted.
- R10: Threshold writes go to staging registers. A write to CTRL with bit 2 set commits them when high ≥ low and clears the error flag (CTRL read bit 7). Otherwise the commit sets the flag and leaves the active thresholds unchanged.
- R11: A checkpoint that arrives during FILL drops the remaining filler, captures a new shortfall and classifies it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Asynchronous checkpoint pulse |
| bclk_tick | input | 1 | One bit-clock period driven on the line |
| slot_tick | input | 1 | Slot boundary; one sample leaves |
| src_data | input | DATA_W | Sample at the head of the FIFO |
| src_pop | output | 1 | Pop the FIFO head this cycle |
| line_data | output | DATA_W | Sample sent to the serializer |
| line_valid | output | 1 | `line_data` is taken this cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Severe drift interrupt, sticky |

## Verification
A checkpoint edge and a slot boundary can fall in the same clock cycle. The counter clear and the shortfall capture then race against a FIFO pop. The bench provokes this by raising `sync_in` and pulsing `slot_tick` exactly two falling edges later, so that the pulse lands in the detector's edge cycle. The result is judged by three things: the FIFO counter reads 1, the captured shortfall leaves out that slot, and the filler that follows repeats the sample popped in the colliding cycle.

// File: rtl/txdc_pkg.sv
package txdc_pkg;
    typedef enum logic [1:0] {
        ST_TRACK = 2'd0,
        ST_JUDGE = 2'd1,
        ST_FILL  = 2'd2
    } txdc_state_e;

    localparam int REG_W   = 32;
    localparam int ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_LOW   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_HIGH  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_IDEAL = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_FILLV = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_BCNT  = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_FCNT  = 3'd6;
    localparam logic [ADDR_W-1:0] ADR_DIFF  = 3'd7;

    localparam int B_EN      = 0;
    localparam int B_MODE    = 1;
    localparam int B_COMMIT  = 2;
    localparam int B_CLR_BC  = 3;
    localparam int B_CLR_FC  = 4;
    localparam int B_CLR_DF  = 5;
    localparam int B_CLR_IRQ = 6;
    localparam int B_CFGERR  = 7;
    localparam int B_IRQ     = 8;
endpackage

// File: rtl/txdc_edge_sync.sv
module txdc_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic edge_o
);
    logic [2:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], async_in};
    end

    assign edge_o = sh_q[1] & ~sh_q[2];

    assert_single_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
endmodule

// File: rtl/txdc_tick_ctr.sv
module txdc_tick_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= CNT_W'(tick);
        else if (tick) cnt <= cnt + 1'b1;
    end

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt <= CNT_W'(1)));
endmodule

// File: rtl/txdc_regs.sv
module txdc_regs
    import txdc_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 32,
    parameter int LOW_RST  = 1,
    parameter int HIGH_RST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [CNT_W-1:0]  bclk_cnt,
    input  logic [CNT_W-1:0]  fifo_cnt,
    input  logic [CNT_W-1:0]  diff,
    input  logic              irq,
    output logic              en,
    output logic              mode,
    output logic [CNT_W-1:0]  act_low,
    output logic [CNT_W-1:0]  act_high,
    output logic [CNT_W-1:0]  ideal,
    output logic [DATA_W-1:0] fill_val,
    output logic              clr_bclk,
    output logic              clr_fifo,
    output logic              clr_diff,
    output logic              clr_irq
);
    logic [CNT_W-1:0] stg_low, stg_high;
    logic             cfg_err;
    logic             ctrl_wr;

    assign ctrl_wr  = reg_we && (reg_addr == ADR_CTRL);
    assign clr_bclk = ctrl_wr && reg_wdata[B_CLR_BC];
    assign clr_fifo = ctrl_wr && reg_wdata[B_CLR_FC];
    assign clr_diff = ctrl_wr && reg_wdata[B_CLR_DF];
    assign clr_irq  = ctrl_wr && reg_wdata[B_CLR_IRQ];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= 1'b0;
            mode     <= 1'b0;
            stg_low  <= CNT_W'(LOW_RST);
            stg_high <= CNT_W'(HIGH_RST);
            act_low  <= CNT_W'(LOW_RST);
            act_high <= CNT_W'(HIGH_RST);
            ideal    <= '0;
            fill_val <= '0;
            cfg_err  <= 1'b0;
        end else if (reg_we) begin
            unique case (reg_addr)
                ADR_CTRL: begin
                    en   <= reg_wdata[B_EN];
                    mode <= reg_wdata[B_MODE];
                    if (reg_wdata[B_COMMIT]) begin
                        if (stg_high >= stg_low) begin
                            act_low  <= stg_low;
                            act_high <= stg_high;
                            cfg_err  <= 1'b0;
                        end else begin
                            cfg_err  <= 1'b1;
                        end
                    end
                end
                ADR_LOW:   stg_low  <= reg_wdata[CNT_W-1:0];
                ADR_HIGH:  stg_high <= reg_wdata[CNT_W-1:0];
                ADR_IDEAL: ideal    <= reg_wdata[CNT_W-1:0];
                ADR_FILLV: fill_val <= reg_wdata[DATA_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADR_CTRL: begin
                reg_rdata[B_EN]     = en;
                reg_rdata[B_MODE]   = mode;
                reg_rdata[B_CFGERR] = cfg_err;
                reg_rdata[B_IRQ]    = irq;
            end
            ADR_LOW:   reg_rdata = REG_W'(act_low);
            ADR_HIGH:  reg_rdata = REG_W'(act_high);
            ADR_IDEAL: reg_rdata = REG_W'(ideal);
            ADR_FILLV: reg_rdata = REG_W'(fill_val);
            ADR_BCNT:  reg_rdata = REG_W'(bclk_cnt);
            ADR_FCNT:  reg_rdata = REG_W'(fifo_cnt);
            ADR_DIFF:  reg_rdata = REG_W'(diff);
            default:   reg_rdata = '0;
        endcase
    end

    assert_thr_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        act_high >= act_low);
endmodule

// File: rtl/txdc_engine.sv
module txdc_engine
    import txdc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_edge,
    input  logic              slot_tick,
    input  logic [DATA_W-1:0] src_data,
    input  logic              en,
    input  logic              mode,
    input  logic [DATA_W-1:0] fill_val,
    input  logic [CNT_W-1:0]  act_low,
    input  logic [CNT_W-1:0]  act_high,
    input  logic [CNT_W-1:0]  ideal,
    input  logic [CNT_W-1:0]  fifo_cnt,
    input  logic              clr_diff,
    input  logic              clr_irq,
    output logic              src_pop,
    output logic [DATA_W-1:0] line_data,
    output logic              line_valid,
    output logic              irq,
    output logic [CNT_W-1:0]  diff
);
    txdc_state_e      state_q, state_d;
    logic [CNT_W-1:0] diff_q, snap;
    logic [DATA_W-1:0] last_q;
    logic             fill_now;
    logic             irq_q;

    assign snap = (fifo_cnt < ideal) ? (ideal - fifo_cnt) : '0;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_TRACK;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TRACK: state_d = ST_TRACK;
            ST_JUDGE: begin
                if (en && diff_q != '0 && diff_q >= act_low && diff_q <= act_high)
                    state_d = ST_FILL;
                else
                    state_d = ST_TRACK;
            end
            ST_FILL: begin
                if (!en || clr_diff || diff_q == '0 ||
                    (fill_now && diff_q == CNT_W'(1)))
                    state_d = ST_TRACK;
            end
            default: state_d = ST_TRACK;
        endcase
        if (sync_edge) state_d = ST_JUDGE;
    end

    // outputs
    always_comb begin
        fill_now   = (state_q == ST_FILL) && slot_tick && en && (diff_q != '0);
        line_valid = slot_tick;
        src_pop    = slot_tick && !fill_now;
        if (fill_now) line_data = mode ? fill_val : last_q;
        else          line_data = src_data;
    end

    // datapath: shortfall, last sample, interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            diff_q <= '0;
            last_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (sync_edge)     diff_q <= snap;
            else if (clr_diff) diff_q <= '0;
            else if (fill_now) diff_q <= diff_q - 1'b1;

            if (slot_tick) last_q <= line_data;

            if (state_q == ST_JUDGE && diff_q > act_high) irq_q <= 1'b1;
            else if (clr_irq)                             irq_q <= 1'b0;
        end
    end

    assign irq  = irq_q;
    assign diff = diff_q;

    assert_diff_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_now && !sync_edge && !clr_diff) |=> (diff_q == $past(diff_q) - 1'b1));

    assert_irq_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JUDGE && diff_q > act_high) |=> irq_q);

    assert_fill_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> $past(en));
endmodule

// File: rtl/txdc_top.sv
module txdc_top
    import txdc_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 32,
    parameter int LOW_RST  = 1,
    parameter int HIGH_RST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_in,
    input  logic              bclk_tick,
    input  logic              slot_tick,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_pop,
    output logic [DATA_W-1:0] line_data,
    output logic              line_valid,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    localparam int NCTR = 2;

    logic                sync_edge;
    logic                en, mode, clr_bclk, clr_fifo, clr_diff, clr_irq;
    logic [CNT_W-1:0]    act_low, act_high, ideal, diff;
    logic [DATA_W-1:0]   fill_val;
    logic [NCTR-1:0]     ctr_tick, ctr_clr;
    logic [CNT_W-1:0]    ctr_val [NCTR];

    txdc_edge_sync u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sync_in), .edge_o(sync_edge)
    );

    assign ctr_tick = {src_pop, bclk_tick};
    assign ctr_clr  = {sync_edge | clr_fifo, sync_edge | clr_bclk};

    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
        txdc_tick_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk(clk), .rst_n(rst_n), .tick(ctr_tick[g]),
            .clr(ctr_clr[g]), .cnt(ctr_val[g])
        );
    end

    txdc_regs #(
        .CNT_W(CNT_W), .DATA_W(DATA_W), .LOW_RST(LOW_RST), .HIGH_RST(HIGH_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .bclk_cnt(ctr_val[0]), .fifo_cnt(ctr_val[1]), .diff(diff), .irq(irq),
        .en(en), .mode(mode), .act_low(act_low), .act_high(act_high),
        .ideal(ideal), .fill_val(fill_val),
        .clr_bclk(clr_bclk), .clr_fifo(clr_fifo), .clr_diff(clr_diff),
        .clr_irq(clr_irq)
    );

    txdc_engine #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .sync_edge(sync_edge),
        .slot_tick(slot_tick), .src_data(src_data),
        .en(en), .mode(mode), .fill_val(fill_val),
        .act_low(act_low), .act_high(act_high), .ideal(ideal),
        .fifo_cnt(ctr_val[1]), .clr_diff(clr_diff), .clr_irq(clr_irq),
        .src_pop(src_pop), .line_data(line_data), .line_valid(line_valid),
        .irq(irq), .diff(diff)
    );
endmodule

// File: tb/txdc_top_bench.sv
module txdc_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_in = 1'b0, bclk_tick = 1'b0, slot_tick = 1'b0;
    logic [31:0] src_data = '0;
    logic        src_pop, line_valid, irq;
    logic [31:0] line_data;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_tests = 0, n_fail = 0;
    logic [32:0] exp_q[$];
    string cur_tag = "R5";

    localparam logic [31:0] STATICV = 32'hCAFEF00D;

    always #10 clk = ~clk;

    txdc_top u_txdc_top (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .bclk_tick(bclk_tick),
        .slot_tick(slot_tick), .src_data(src_data), .src_pop(src_pop),
        .line_data(line_data), .line_valid(line_valid),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected slot outputs
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (line_valid) begin
                if (exp_q.size() == 0) begin
                    chk({cur_tag, " unexpected slot"}, 32'd1, 32'd0);
                end else begin
                    logic [32:0] e;
                    e = exp_q.pop_front();
                    chk({cur_tag, " slot pop"}, {31'd0, src_pop}, {31'd0, e[32]});
                    chk({cur_tag, " slot data"}, line_data, e[31:0]);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic ctrl(input logic en, input logic md, input logic [6:0] pulses);
        wr(3'd0, {25'd0, pulses[6:2], md, en});
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); reg_addr = a; #1;
        chk(tag, reg_rdata, exp);
    endtask

    // driver: one slot; expected item pushed to scoreboard
    task automatic slot(input logic [31:0] d, input logic [31:0] exp_d, input logic exp_pop);
        @(negedge clk);
        exp_q.push_back({exp_pop, exp_d});
        slot_tick = 1'b1; src_data = d;
        @(negedge clk);
        slot_tick = 1'b0;
    endtask

    task automatic pass(input logic [31:0] d);
        slot(d, d, 1'b1);
    endtask

    task automatic sync_pulse();
        @(negedge clk); sync_in = 1'b1;
        repeat (4) @(negedge clk);
        sync_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        chk("R7 reset irq", {31'd0, irq}, 32'd0);
        rd(3'd5, 0, "R2 reset bclk count");
        rd(3'd6, 0, "R2 reset fifo count");
        rd(3'd7, 0, "R4 reset diff");
        rd(3'd1, 1, "R10 reset low");
        rd(3'd2, 8, "R10 reset high");

        // R2: counting
        cur_tag = "R2";
        repeat (5) begin
            @(negedge clk); bclk_tick = 1'b1;
            @(negedge clk); bclk_tick = 1'b0;
        end
        pass(32'h11); pass(32'h12); pass(32'h13);
        rd(3'd5, 5, "R2 bclk count");
        rd(3'd6, 3, "R2 fifo count");
        ctrl(0, 0, 7'b0001000);
        rd(3'd5, 0, "R3 sw clear bclk");
        rd(3'd6, 3, "R3 fifo kept on bclk clear");

        // thresholds low=2 high=5
        wr(3'd1, 2); wr(3'd2, 5); ctrl(0, 0, 7'b0000100);
        rd(3'd1, 2, "R10 commit low");
        rd(3'd2, 5, "R10 commit high");
        wr(3'd4, STATICV);

        // R5: shortfall 1 < low
        cur_tag = "R5";
        wr(3'd3, 4); ctrl(1, 1, 7'b0010000);
        repeat (5) begin
            @(negedge clk); bclk_tick = 1'b1;
            @(negedge clk); bclk_tick = 1'b0;
        end
        pass(32'h21); pass(32'h22); pass(32'h23);
        sync_pulse();
        rd(3'd7, 1, "R4 captured diff");
        rd(3'd5, 0, "R3 bclk cleared by checkpoint");
        rd(3'd6, 0, "R3 fifo cleared by checkpoint");
        pass(32'h24);

        // R6/R8 static filler
        cur_tag = "R6";
        wr(3'd3, 10); ctrl(1, 1, 7'b0010000);
        for (int i = 0; i < 7; i++) pass(32'h30 + i);
        sync_pulse();
        rd(3'd7, 3, "R6 diff before fill");
        repeat (3) slot(32'hDEAD, STATICV, 1'b0);
        rd(3'd7, 0, "R6 diff drained");
        pass(32'h40);

        // R8 repeat last
        cur_tag = "R8";
        ctrl(1, 0, 7'b0010000);
        for (int i = 0; i < 7; i++) pass(32'h50 + i);
        sync_pulse();
        repeat (3) slot(32'hBEEF, 32'h56, 1'b0);
        pass(32'h60);

        // R7 severe drift
        cur_tag = "R7";
        wr(3'd3, 20); ctrl(1, 0, 7'b0010000);
        pass(32'h70); pass(32'h71);
        sync_pulse();
        rd(3'd7, 18, "R7 diff above high");
        chk("R7 irq raised", {31'd0, irq}, 32'd1);
        rd(3'd0, 32'h101, "R7 ctrl irq bit");
        pass(32'h72);
        ctrl(1, 0, 7'b1000000);
        chk("R7 irq cleared", {31'd0, irq}, 32'd0);

        // R9 disabled
        cur_tag = "R9";
        wr(3'd3, 10); ctrl(0, 0, 7'b0010000);
        for (int i = 0; i < 7; i++) pass(32'h80 + i);
        sync_pulse();
        rd(3'd7, 3, "R9 diff captured while disabled");
        pass(32'h90);
        rd(3'd6, 1, "R9 fifo counts while disabled");
        ctrl(0, 0, 7'b0100000);
        rd(3'd7, 0, "R4 sw clear diff");

        // R10 invalid commit
        wr(3'd1, 6); wr(3'd2, 3); ctrl(0, 0, 7'b0000100);
        rd(3'd0, 32'h80, "R10 cfg error flag");
        rd(3'd1, 2, "R10 low unchanged");
        rd(3'd2, 5, "R10 high unchanged");
        wr(3'd1, 1); wr(3'd2, 5); ctrl(0, 0, 7'b0000100);
        rd(3'd0, 32'h0, "R10 error cleared");
        rd(3'd1, 1, "R10 low applied");

        // R11 checkpoint during fill
        cur_tag = "R11";
        wr(3'd3, 4); ctrl(1, 1, 7'b0010000);
        pass(32'hA0);
        sync_pulse();
        slot(32'h0, STATICV, 1'b0);
        sync_pulse();
        rd(3'd7, 4, "R11 re-captured diff");
        repeat (4) slot(32'h0, STATICV, 1'b0);
        pass(32'hA1);

        // R3 collision: checkpoint edge and slot in same cycle
        cur_tag = "R3";
        ctrl(1, 0, 7'b0010000);
        pass(32'hB0); pass(32'hB1);
        @(negedge clk); sync_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        exp_q.push_back({1'b1, 32'hC0});
        slot_tick = 1'b1; src_data = 32'hC0;
        @(negedge clk); slot_tick = 1'b0;
        @(negedge clk); sync_in = 1'b0;
        @(negedge clk);
        rd(3'd6, 1, "R3 collision slot in new interval");
        rd(3'd7, 2, "R3 collision slot excluded from diff");
        repeat (2) slot(32'h0, 32'hC0, 1'b0);
        pass(32'hC1);

        // R1 held level gives one checkpoint
        cur_tag = "R1";
        ctrl(0, 0, 7'b0010000);
        pass(32'hD0);
        @(negedge clk); sync_in = 1'b1;
        repeat (4) @(negedge clk);
        pass(32'hD1); pass(32'hD2);
        repeat (3) @(negedge clk);
        sync_in = 1'b0;
        repeat (3) @(negedge clk);
        rd(3'd6, 2, "R1 single checkpoint fifo count");
        rd(3'd7, 3, "R1 single checkpoint diff");

        repeat (3) @(negedge clk);
        chk("R6 scoreboard drained", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule